// File: doc/BRIEF.md
# Dual-Period Watchdog Reset Supervisor

This block keeps watch over a processor through one kick line. Software is expected to flip that line, in either direction, more often than a set number of timebase cycles. When the line stays still too long, the block drives a reset pulse of a set length onto two outputs: one active low and one active high, always complementary. It also owns the reset that follows power-on and any supply-low event. That reset is held for as long as the condition lasts, and a full-width pulse follows once the condition clears.

Two timeout lengths are used. Right after any reset ends, the supervisor gives the processor a long grace window, because start-up code may not service the watchdog at once. The first kick edge seen with reset released switches it to the short window, and each later edge restarts that window. A mode input makes both windows long. A monitor-enable input turns the watchdog off entirely. A width input chooses a narrow or a wide reset pulse.

Top module: `wdg_supervisor`

## Requirements
- R1: `sys_rst_o` is at all times the logical inverse of `sys_rst_n_o`.
- R2: While `por_n` is low or `supply_low` is high, reset is active (`sys_rst_n_o` = 0) by the clock edge after `supply_low` rises. After `supply_low` falls, reset stays active for one cycle and then for exactly the pulse width, before it releases.
- R3: The reset pulse lasts 512 cycles when `wide_pulse` = 0 and 2048 cycles when `wide_pulse` = 1.
- R4: After any reset ends, reset stays released for the long timeout of 4096 cycles if no kick edge arrives.
- R5: With `kick` held constant and monitoring enabled, the outputs repeat a pattern of 4096 released cycles and one pulse width of active reset.
- R6: A rising edge and a falling edge on `kick` both restart the timeout. After the first edge following release, the short timeout of 1024 cycles applies. Counting the first clock edge after `kick` changes as edge 1, reset goes active after clock edge 1027 (two synchronizer stages plus one edge-detect stage).
- R7: Kick edges that occur while reset is active do not select the short timeout. The next release still lasts 4096 cycles.
- R8: With `long_only` = 1, the timeout after a kick edge is 4096 cycles. Reset goes active after clock edge 4099, counted as in R6.
- R9: With `mon_en` = 0, no watchdog reset occurs, however long `kick` stays still.
- R10: The timeout count restarts at the end of a reset that came from `supply_low`. A full 4096-cycle window follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock; all timing is counted in its cycles |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| kick | input | 1 | Processor activity line, asynchronous; any edge is a kick |
| mon_en | input | 1 | 1 enables the watchdog; 0 disables watchdog resets |
| long_only | input | 1 | 1 uses the long timeout in all cases |
| wide_pulse | input | 1 | 0 selects the narrow reset pulse, 1 the wide one |
| supply_low | input | 1 | Digital supply-fault flag, active high |
| sys_rst_n_o | output | 1 | Processor reset, active low |
| sys_rst_o | output | 1 | Processor reset, active high, inverse of sys_rst_n_o |

## Verification
A wrong grace flag shows up at the ports as a released stretch of 1024 cycles where 4096 were due, or the other way round. The difference appears at the very first reset after the fault. A timeout counter that slips or fails to restart moves the falling edge of `sys_rst_n_o` away from its exact cycle, so the bench measures every stretch of reset and release to the cycle. A fault in the pulse counter or the supervisor state changes the length of the next active-reset stretch, or keeps reset from releasing, and shows up within one pulse width.

// File: rtl/wdg_pkg.sv
`timescale 1ns/1ps
package wdg_pkg;

  typedef enum logic [1:0] {
    SUP_HOLD  = 2'd0,
    SUP_PULSE = 2'd1,
    SUP_RUN   = 2'd2
  } sup_state_e;

  // Timeout length in cycles for the current mode.
  function automatic int unsigned pick_timeout(input logic grace,
                                               input logic long_only,
                                               input int unsigned short_c,
                                               input int unsigned long_c);
    return (grace || long_only) ? long_c : short_c;
  endfunction

  // Reset pulse length in cycles.
  function automatic int unsigned pick_width(input logic wide,
                                             input int unsigned narrow_c,
                                             input int unsigned wide_c);
    return wide ? wide_c : narrow_c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wdg_kick_sync.sv
`timescale 1ns/1ps
module wdg_kick_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic kick,
  output logic kick_edge
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_sync
    if (gi == 0) begin : g_first
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= kick;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) sync_q[gi] <= 1'b0;
        else        sync_q[gi] <= sync_q[gi-1];
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) last_q <= 1'b0;
    else        last_q <= sync_q[STAGES-1];
  end

  // An edge in either direction counts as activity.
  assign kick_edge = sync_q[STAGES-1] ^ last_q;

endmodule

// File: rtl/wdg_timeout.sv
`timescale 1ns/1ps
module wdg_timeout
  import wdg_pkg::*;
#(
  parameter int unsigned SHORT_CYC = 1024,
  parameter int unsigned LONG_CYC  = 4096
) (
  input  logic clk,
  input  logic por_n,
  input  logic run,
  input  logic mon_en,
  input  logic long_only,
  input  logic kick_edge,
  output logic expire,
  output logic grace_o
);

  localparam int unsigned TOP_C = max_u(SHORT_CYC, LONG_CYC);
  localparam int unsigned CW    = $clog2(TOP_C + 1);
  localparam logic [CW-1:0] SAT_M1 = CW'(TOP_C - 1);

  logic [CW-1:0] cnt_q;
  logic          grace_q;
  logic [CW-1:0] lim_m1;

  assign lim_m1  = CW'(pick_timeout(grace_q, long_only, SHORT_CYC, LONG_CYC) - 1);
  assign expire  = run && mon_en && !kick_edge && (cnt_q >= lim_m1);
  assign grace_o = grace_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q   <= '0;
      grace_q <= 1'b1;
    end else if (!run) begin
      // Any active reset re-arms the grace window and clears the count.
      cnt_q   <= '0;
      grace_q <= 1'b1;
    end else begin
      if (kick_edge) grace_q <= 1'b0;
      if (kick_edge || !mon_en) cnt_q <= '0;
      else if (cnt_q != SAT_M1) cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!por_n)
    cnt_q <= SAT_M1);

  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(run) |-> (cnt_q == '0));

  // R7
  grace_rearm_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(run) |-> grace_q);

  // R6
  expire_late_chk: assert property (@(posedge clk) disable iff (!por_n)
    expire |-> (cnt_q >= CW'(SHORT_CYC - 1)));

endmodule

// File: rtl/wdg_pulse.sv
`timescale 1ns/1ps
module wdg_pulse
  import wdg_pkg::*;
#(
  parameter int unsigned NARROW_CYC = 512,
  parameter int unsigned WIDE_CYC   = 2048
) (
  input  logic clk,
  input  logic por_n,
  input  logic supply_low,
  input  logic expire,
  input  logic wide_pulse,
  output logic run
);

  localparam int unsigned TOP_W = max_u(NARROW_CYC, WIDE_CYC);
  localparam int unsigned PW    = $clog2(TOP_W + 1);

  sup_state_e    state_q;
  logic [PW-1:0] pcnt_q;
  logic [PW-1:0] wlim_m1;

  assign wlim_m1 = PW'(pick_width(wide_pulse, NARROW_CYC, WIDE_CYC) - 1);
  assign run     = (state_q == SUP_RUN);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state_q <= SUP_HOLD;
      pcnt_q  <= '0;
    end else if (supply_low) begin
      state_q <= SUP_HOLD;
      pcnt_q  <= '0;
    end else begin
      unique case (state_q)
        SUP_HOLD: begin
          state_q <= SUP_PULSE;
          pcnt_q  <= '0;
        end
        SUP_PULSE: begin
          if (pcnt_q >= wlim_m1) begin
            state_q <= SUP_RUN;
            pcnt_q  <= '0;
          end else begin
            pcnt_q <= pcnt_q + 1'b1;
          end
        end
        SUP_RUN: begin
          if (expire) begin
            state_q <= SUP_PULSE;
            pcnt_q  <= '0;
          end
        end
        default: begin
          state_q <= SUP_HOLD;
          pcnt_q  <= '0;
        end
      endcase
    end
  end

  // R2
  supply_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    supply_low |=> !run);

  // R3
  width_bound_chk: assert property (@(posedge clk) disable iff (!por_n)
    pcnt_q <= PW'(TOP_W - 1));

  // R3
  pulse_entry_chk: assert property (@(posedge clk) disable iff (!por_n)
    (run && expire && !supply_low) |=> (!run && pcnt_q == '0));

endmodule

// File: rtl/wdg_supervisor.sv
`timescale 1ns/1ps
module wdg_supervisor #(
  parameter int unsigned SHORT_CYC  = 1024,
  parameter int unsigned LONG_CYC   = 4096,
  parameter int unsigned NARROW_CYC = 512,
  parameter int unsigned WIDE_CYC   = 2048,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic kick,
  input  logic mon_en,
  input  logic long_only,
  input  logic wide_pulse,
  input  logic supply_low,
  output logic sys_rst_n_o,
  output logic sys_rst_o
);

  logic kick_edge;
  logic expire;
  logic run;
  logic grace;

  wdg_kick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .por_n     (por_n),
    .kick      (kick),
    .kick_edge (kick_edge)
  );

  wdg_timeout #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_tmo (
    .clk       (clk),
    .por_n     (por_n),
    .run       (run),
    .mon_en    (mon_en),
    .long_only (long_only),
    .kick_edge (kick_edge),
    .expire    (expire),
    .grace_o   (grace)
  );

  wdg_pulse #(.NARROW_CYC(NARROW_CYC), .WIDE_CYC(WIDE_CYC)) u_pls (
    .clk        (clk),
    .por_n      (por_n),
    .supply_low (supply_low),
    .expire     (expire),
    .wide_pulse (wide_pulse),
    .run        (run)
  );

  assign sys_rst_n_o = run;
  assign sys_rst_o   = ~run;

  // R9
  disabled_chk: assert property (@(posedge clk) disable iff (!por_n)
    (run && !mon_en && !supply_low) |=> run);

  // R6
  kick_restart_chk: assert property (@(posedge clk) disable iff (!por_n)
    (run && kick_edge && !supply_low) |=> run);

  // R7
  grace_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    !run |=> grace);

endmodule

// File: tb/sim_wdg_supervisor.sv
`timescale 1ns/1ps
module sim_wdg_supervisor;

  localparam int SHORT_C  = 1024;
  localparam int LONG_C   = 4096;
  localparam int NARROW_C = 512;
  localparam int WIDE_C   = 2048;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic kick = 1'b0;
  logic mon_en = 1'b1;
  logic long_only = 1'b0;
  logic wide_pulse = 1'b0;
  logic supply_low = 1'b1;
  logic sys_rst_n_o, sys_rst_o;

  int vectors = 0;
  int miscompares = 0;

  // Scoreboard: expected stretches of sys_rst_n_o (level, length in cycles).
  bit exp_lvl[$];
  int exp_len[$];

  always #10 clk = ~clk;

  wdg_supervisor u0 (
    .clk(clk), .por_n(por_n), .kick(kick), .mon_en(mon_en),
    .long_only(long_only), .wide_pulse(wide_pulse), .supply_low(supply_low),
    .sys_rst_n_o(sys_rst_n_o), .sys_rst_o(sys_rst_o)
  );

  task automatic check(input string req, input int got, input int want);
    vectors++;
    if (got != want) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", req, got, want);
    end
  endtask

  task automatic push_exp(input bit lvl, input int len);
    @(posedge clk);
    exp_lvl.push_back(lvl);
    exp_len.push_back(len);
  endtask

  task automatic drain();
    while (exp_len.size() != 0) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_level(input bit lvl);
    @(negedge clk);
    while (sys_rst_n_o !== lvl) @(negedge clk);
  endtask

  // Counts clock edges until sys_rst_n_o shows lvl at a falling edge.
  task automatic count_until(input bit lvl, input int limit, output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (sys_rst_n_o !== lvl && n < limit);
  endtask

  // Monitor: complement check and stretch comparison.
  bit prev_lvl = 1'b0;
  int run_len = 0;
  always @(negedge clk) begin
    vectors++;
    if (sys_rst_o !== ~sys_rst_n_o) begin
      miscompares++;
      $display("FAIL R1: rst_o %b rst_n_o %b expected inverse", sys_rst_o, sys_rst_n_o);
    end
    if (sys_rst_n_o === prev_lvl) begin
      run_len++;
    end else begin
      if (exp_len.size() != 0) begin
        automatic bit el = exp_lvl.pop_front();
        automatic int en = exp_len.pop_front();
        vectors++;
        if (el != prev_lvl || en != run_len) begin
          miscompares++;
          $display("FAIL R3/R4/R5/R10: stretch level %0d len %0d expected level %0d len %0d",
                   prev_lvl, run_len, el, en);
        end
      end
      prev_lvl = sys_rst_n_o;
      run_len = 1;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int n;
    int lows;
    // Reset state (R1, R2)
    repeat (3) @(negedge clk);
    check("R2 por active", sys_rst_n_o, 0);
    check("R1 por active", sys_rst_o, 1);
    por_n = 1'b1;
    repeat (20) @(negedge clk);
    check("R2 held by supply_low", sys_rst_n_o, 0);
    supply_low = 1'b0;
    count_until(1'b1, 10000, n);
    check("R2 R3 narrow pulse after supply release", n, NARROW_C + 1);

    // R4 grace, R5 repeating pulses with constant kick
    push_exp(1'b1, LONG_C);
    push_exp(1'b0, NARROW_C);
    push_exp(1'b1, LONG_C);
    drain();

    // R3 wide pulse
    wait_level(1'b1);
    wide_pulse = 1'b1;
    push_exp(1'b1, LONG_C);
    push_exp(1'b0, WIDE_C);
    push_exp(1'b1, LONG_C);
    drain();
    wait_level(1'b1);
    wide_pulse = 1'b0;

    // R6 both edge directions, short timeout after first edge
    for (int i = 0; i < 4; i++) begin
      kick = ~kick;
      repeat (300) @(negedge clk);
      check("R6 kicks keep reset released", sys_rst_n_o, 1);
    end
    kick = ~kick;  // rising edge (fifth toggle from 0)
    count_until(1'b0, 10000, n);
    check("R6 short timeout after rising kick", n, SHORT_C + 3);
    push_exp(1'b0, NARROW_C);
    push_exp(1'b1, LONG_C);
    drain();

    // R8 long-only mode after a falling kick
    long_only = 1'b1;
    wait_level(1'b1);
    repeat (10) @(negedge clk);
    kick = 1'b0;
    count_until(1'b0, 10000, n);
    check("R8 long-only timeout after falling kick", n, LONG_C + 3);
    long_only = 1'b0;

    // R9 monitor disabled
    mon_en = 1'b0;
    wait_level(1'b1);
    kick = 1'b1;
    lows = 0;
    for (int i = 0; i < 9000; i++) begin
      @(negedge clk);
      if (sys_rst_n_o !== 1'b1) lows++;
    end
    check("R9 no reset while disabled", lows, 0);
    mon_en = 1'b1;

    // R2 supply-low during run, R7 kicks during reset, R10 restart
    repeat (100) @(negedge clk);
    check("R9 released before supply fault", sys_rst_n_o, 1);
    supply_low = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R2 supply_low asserts reset", sys_rst_n_o, 0);
    for (int i = 0; i < 7; i++) begin
      kick = ~kick;
      repeat (10) @(negedge clk);
    end
    repeat (30) @(negedge clk);
    check("R2 still held", sys_rst_n_o, 0);
    supply_low = 1'b0;
    count_until(1'b1, 10000, n);
    check("R2 pulse after supply release", n, NARROW_C + 1);
    push_exp(1'b1, LONG_C);  // R7 R10
    drain();

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule